// File: doc/BRIEF.md
# Self-Test Loop Receive Checker

This block sits on the receive side of a serial link and checks a built-in self-test stream. The far end sends a fixed pseudo-random sequence of 511 symbols, over and over. The checker first hunts for the symbol that opens the sequence. It then follows the stream symbol by symbol against its own copy of the sequence and counts every mismatch. If errors become too dense, it gives up its lock and starts hunting again.

While self-test is enabled (the enable input is active low), the checker's single progress flag replaces the receive buffer's full flag on the shared output. Before lock, the flag is held high. After lock, the flag is low except for a one-clock pulse that marks the last symbol of each pass through the loop. When self-test is disabled, the output passes the normal full flag through unchanged.

Top module: `bist_loop_checker`

## Requirements
- R1: While `bistEnN` is 1, `fullOut` equals `fifoFullIn` in the same cycle, `locked` stays 0 and incoming symbols, including 0x1FF, have no effect.
- R2: While `bistEnN` is 0 and the checker is not locked, `fullOut` is held at 1 whatever `fifoFullIn` is and whatever non-start symbols arrive.
- R3: While enabled and unlocked, a valid symbol equal to 0x1FF (the loop start, loop position 0) sets `locked` to 1 and drops `fullOut` to 0 after that clock edge.
- R4: Once locked, each valid symbol is compared with the next term of the sequence s(k+1) = {s(k)[7:0], s(k)[8] ^ s(k)[4]}, which starts from s(0) = 0x1FF and repeats every 511 symbols. Every mismatch adds one to `errCount` at that edge, and a matching stream adds nothing.
- R5: When locked, the valid symbol at loop position 510 makes `fullOut` read 1 for exactly the one clock that follows its edge. At every other locked position, `fullOut` reads 0.
- R6: A cycle with `symValid` at 0 is ignored. It neither locks, nor advances the loop position, nor counts an error, whatever `symIn` holds.
- R7: The checker remains locked while 13 or fewer of the last 28 compared symbols are in error. At the edge where the count reaches 14, `locked` falls and `fullOut` returns to held-high.
- R8: Each new lock starts with an empty error window, so errors from before the lock cannot cause a later loss of lock.
- R9: `errCount` counts only symbols compared while locked. It saturates at its all-ones value rather than wrapping, and the first edge with `bistEnN` at 1 clears it to 0.
- R10: While `bistEnN` is 0, `fifoFullIn` has no effect on `fullOut`, either before lock or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive symbol clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bistEnN | input | 1 | Self-test enable, active low |
| symValid | input | 1 | `symIn` holds a received symbol this cycle |
| symIn | input | SYM_W (9) | Received symbol |
| fifoFullIn | input | 1 | Full flag from the receive buffer |
| fullOut | output | 1 | Full flag, or the self-test progress flag while self-test is enabled |
| locked | output | 1 | Checker is tracking the loop |
| errCount | output | CNT_W (16) | Saturating count of mismatched symbols while locked |

## Verification
Three kinds of result have different timing, and the bench samples each one to match:

- **Same cycle:** the selection of `fifoFullIn` while disabled is combinational, so it is visible at once.
- **One edge later:** `locked`, `errCount` and the held-high flag all update one register stage after the edge that accepts a symbol.
- **One clock after the edge:** the loop-end pulse appears in the clock after the edge that takes the position-510 symbol, and it is gone one clock later.

The bench changes inputs only at a falling edge and reads the outputs at the next falling edge. In this way, every comparison sees exactly the state after one rising edge. A second instance with a 4-bit error counter reaches saturation within the same stimulus.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;   // start-of-loop seen: restart tracking
    logic advance;     // compare the current symbol and step the loop
    logic clearCnt;    // self-test disabled: clear the error count
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic isStart;     // symbol equals the loop-start value
    logic isLast;      // the expected symbol is the last of the loop
    logic symErr;      // symbol differs from the expected value
    logic tooDense;    // the window would reach the error limit
  } dpStat_t;

  typedef enum logic { SEARCH = 1'b0, TRACK = 1'b1 } lockState_t;

endpackage

// File: rtl/bist_chk_datapath.sv
module bist_chk_datapath
  import bist_chk_pkg::*;
#(
  parameter int SYM_W   = 9,
  parameter int TAP     = 5,
  parameter int WIN     = 28,
  parameter int ERR_LIM = 14,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] symIn,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat,
  output logic [CNT_W-1:0] errCount
);

  localparam int LAST = (2 ** SYM_W) - 2;
  localparam int WC_W = $clog2(WIN + 1);

  logic [SYM_W-1:0] expSym;
  logic [SYM_W-1:0] pos;
  logic [WIN-1:0]   errWin;
  logic [WC_W-1:0]  winCnt;
  logic [WC_W:0]    newCnt;

  function automatic logic [SYM_W-1:0] stepSeq(input logic [SYM_W-1:0] s);
    return {s[SYM_W-2:0], s[SYM_W-1] ^ s[TAP-1]};
  endfunction

  always_comb begin
    stat.isStart  = (symIn == {SYM_W{1'b1}});
    stat.isLast   = (pos == SYM_W'(LAST));
    stat.symErr   = (symIn != expSym);
    newCnt        = {1'b0, winCnt} + {{WC_W{1'b0}}, stat.symErr}
                    - {{WC_W{1'b0}}, errWin[WIN-1]};
    stat.tooDense = (newCnt >= (WC_W + 1)'(ERR_LIM));
  end

  // expected symbol, loop position and error window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expSym <= '1;
      pos    <= '0;
      errWin <= '0;
      winCnt <= '0;
    end else if (ctrl.loadStart) begin
      expSym <= stepSeq({SYM_W{1'b1}});
      pos    <= SYM_W'(1);
      errWin <= '0;
      winCnt <= '0;
    end else if (ctrl.advance) begin
      expSym <= stepSeq(expSym);
      pos    <= stat.isLast ? '0 : pos + 1'b1;
      errWin <= {errWin[WIN-2:0], stat.symErr};
      winCnt <= newCnt[WC_W-1:0];
    end
  end

  // saturating mismatch counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      errCount <= '0;
    else if (ctrl.clearCnt)
      errCount <= '0;
    else if (ctrl.advance && stat.symErr && (errCount != {CNT_W{1'b1}}))
      errCount <= errCount + 1'b1;
  end

  a_r1_pos_in_loop: assert property (@(posedge clk) disable iff (!rstN)
    pos <= SYM_W'(LAST));

  a_r7_window_tally: assert property (@(posedge clk) disable iff (!rstN)
    winCnt == WC_W'($countones(errWin)));

  a_r9_clear_on_disable: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearCnt |=> (errCount == '0));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == {CNT_W{1'b1}} && !ctrl.clearCnt) |=> (errCount == {CNT_W{1'b1}}));

endmodule

// File: rtl/bist_chk_control.sv
module bist_chk_control
  import bist_chk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bistEnN,
  input  logic    symValid,
  input  logic    fifoFullIn,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    locked,
  output logic    fullOut
);

  lockState_t state;
  logic       pulseQ;
  logic       bistActive;

  always_comb begin
    bistActive     = !bistEnN;
    ctrl.loadStart = bistActive && (state == SEARCH) && symValid && stat.isStart;
    ctrl.advance   = bistActive && (state == TRACK) && symValid;
    ctrl.clearCnt  = !bistActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= SEARCH;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= ctrl.advance && stat.isLast;
      if (!bistActive)
        state <= SEARCH;
      else if (ctrl.loadStart)
        state <= TRACK;
      else if (ctrl.advance && stat.tooDense)
        state <= SEARCH;
    end
  end

  assign locked  = (state == TRACK);
  assign fullOut = bistActive ? (!locked || pulseQ) : fifoFullIn;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> !pulseQ);

  a_r7_drop_lock: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && stat.tooDense) |=> !locked);

  a_r3_acquire: assert property (@(posedge clk) disable iff (!rstN)
    (!bistEnN && !locked && symValid && stat.isStart) |=> locked);

endmodule

// File: rtl/bist_loop_checker.sv
module bist_loop_checker
  import bist_chk_pkg::*;
#(
  parameter int SYM_W   = 9,
  parameter int TAP     = 5,
  parameter int WIN     = 28,
  parameter int ERR_LIM = 14,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bistEnN,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn,
  input  logic             fifoFullIn,
  output logic             fullOut,
  output logic             locked,
  output logic [CNT_W-1:0] errCount
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  bist_chk_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bistEnN    (bistEnN),
    .symValid   (symValid),
    .fifoFullIn (fifoFullIn),
    .stat       (stat),
    .ctrl       (ctrl),
    .locked     (locked),
    .fullOut    (fullOut)
  );

  bist_chk_datapath #(
    .SYM_W   (SYM_W),
    .TAP     (TAP),
    .WIN     (WIN),
    .ERR_LIM (ERR_LIM),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .symIn    (symIn),
    .ctrl     (ctrl),
    .stat     (stat),
    .errCount (errCount)
  );

endmodule

// File: tb/sim_bist_loop_checker.sv
`timescale 1ns/1ps
module sim_bist_loop_checker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bistEnN = 1'b1;
  logic        symValid = 1'b0;
  logic [8:0]  symIn = '0;
  logic        fifoFullIn = 1'b0;
  logic        fullOut, fullOut1;
  logic        locked, locked1;
  logic [15:0] errCount;
  logic [3:0]  errCount1;

  int checks = 0;
  int errors = 0;
  logic [8:0] expS;
  int benchPos;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bist_loop_checker u0 (
    .clk(clk), .rstN(rstN), .bistEnN(bistEnN), .symValid(symValid),
    .symIn(symIn), .fifoFullIn(fifoFullIn),
    .fullOut(fullOut), .locked(locked), .errCount(errCount)
  );

  // narrow counter copy to reach saturation quickly
  bist_loop_checker #(.CNT_W(4)) u1 (
    .clk(clk), .rstN(rstN), .bistEnN(bistEnN), .symValid(symValid),
    .symIn(symIn), .fifoFullIn(fifoFullIn),
    .fullOut(fullOut1), .locked(locked1), .errCount(errCount1)
  );

  function automatic logic [8:0] nextS(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic step(input logic [8:0] s, input logic v);
    symIn = s;
    symValid = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic advBench();
    expS = nextS(expS);
    benchPos = (benchPos == 510) ? 0 : benchPos + 1;
  endtask

  task automatic sendBad(input int n);
    for (int i = 0; i < n; i++) begin
      step(expS ^ 9'h001, 1'b1);
      advBench();
    end
  endtask

  task automatic lockNow(input string req);
    step(9'h1FF, 1'b1);
    expS = nextS(9'h1FF);
    benchPos = 1;
    chk({req, " locked after start"}, locked, 1);
    chk({req, " flag low after start"}, fullOut, 0);
  endtask

  task automatic testReset();
    chk("R1 reset locked", locked, 0);
    chk("R1 reset errCount", errCount, 0);
    chk("R1 reset fullOut", fullOut, 0);
  endtask

  task automatic testDisabledMux();
    fifoFullIn = 1'b1;
    step(9'h1FF, 1'b1);
    chk("R1 fullOut follows 1", fullOut, 1);
    chk("R1 start ignored when disabled", locked, 0);
    fifoFullIn = 1'b0;
    #1;
    chk("R1 fullOut follows 0", fullOut, 0);
    @(negedge clk);
  endtask

  task automatic testSearchHeld();
    bistEnN = 1'b0;
    fifoFullIn = 1'b0;
    step(9'h0AA, 1'b1);
    chk("R2 held high before lock", fullOut, 1);
    chk("R10 fifoFullIn ignored before lock", fullOut, 1);
    step(9'h155, 1'b1);
    chk("R2 still unlocked", locked, 0);
    step(9'h1FF, 1'b0);
    chk("R6 invalid start ignored", locked, 0);
    chk("R2 held high", fullOut, 1);
  endtask

  task automatic testLoops();
    int pulses = 0;
    fifoFullIn = 1'b1;
    lockNow("R3");
    for (int i = 0; i < 1021; i++) begin
      step(expS, 1'b1);
      chk("R5 flag at position", fullOut, (benchPos == 510) ? 1 : 0);
      if (fullOut) pulses++;
      advBench();
      if (i % 97 == 96) begin
        step(9'h000, 1'b0);
        chk("R5 pulse one clock / R6 idle", fullOut, 0);
        chk("R6 idle no error", errCount, 0);
      end
    end
    chk("R5 pulses in two loops", pulses, 2);
    chk("R4 clean stream no errors", errCount, 0);
    chk("R10 still locked with fifoFullIn high", locked, 1);
  endtask

  task automatic testErrors();
    fifoFullIn = 1'b0;
    sendBad(13);
    chk("R4 mismatches counted", errCount, 13);
    chk("R7 13 errors keeps lock", locked, 1);
    for (int i = 0; i < 30; i++) begin
      step(expS, 1'b1);
      advBench();
    end
    chk("R7 lock kept after clean run", locked, 1);
    sendBad(13);
    chk("R7 13 in window still locked", locked, 1);
    sendBad(1);
    chk("R7 14th error drops lock", locked, 0);
    chk("R7 flag held after drop", fullOut, 1);
    chk("R4 count at drop", errCount, 27);
    chk("R9 saturated narrow counter", errCount1, 15);
    for (int i = 0; i < 5; i++) step(9'h000, 1'b1);
    chk("R9 no counting while unlocked", errCount, 27);
    chk("R7 flag held while searching", fullOut, 1);
  endtask

  task automatic testRelock();
    lockNow("R3 relock");
    sendBad(1);
    chk("R8 window cleared on relock", locked, 1);
    chk("R9 count continues", errCount, 28);
  endtask

  task automatic testDisable();
    fifoFullIn = 1'b0;
    bistEnN = 1'b1;
    step(9'h000, 1'b0);
    chk("R9 count cleared on disable", errCount, 0);
    chk("R9 narrow count cleared", errCount1, 0);
    chk("R1 unlocked when disabled", locked, 0);
    chk("R1 fullOut follows input", fullOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabledMux();
    testSearchHeld();
    testLoops();
    testErrors();
    testRelock();
    testDisable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule